// File: doc/BRIEF.md
# Nonvolatile Shadow RAM Controller

This block holds a small working RAM next to a nonvolatile shadow copy of the same size, together with a sequencer that moves data between them. A store copies the working RAM into the shadow, one word per cycle. A recall clears the working RAM and then refills it from the shadow. Both operations end with a fixed settle delay, and a busy output stays high for the whole operation.

Ordinary reads and writes enter through one request channel with valid/ready. A request is taken only on a cycle where both `req_valid` and `req_ready` are high. The requester must hold the request stable until it is taken. `req_ready` is low while an operation runs and while a corrupted write is being refused. Read data comes back on a response channel with no back-pressure: `rsp_valid` pulses for one cycle, one cycle after the read is taken.

Two digital power-status inputs drive automatic behaviour:
- **Supply below the switch level.** Writes, software stores and software recalls are blocked. If the RAM holds unsaved writes, an automatic store runs.
- **Supply below the reset level.** A recall request is latched. It runs once both power-status inputs are low again.

Top module: `nvsram_ctrl`

## Requirements
- R1: A read that is taken returns `rsp_valid`=1 on the next cycle, with `rsp_rdata` equal to the word last written to that address.
- R2: A write that is taken while `below_switch`=0 updates the addressed word. A write taken while `below_switch`=1 leaves the RAM unchanged. Reads still work while `below_switch`=1.
- R3: A store keeps `busy` high for DEPTH+EXTRA cycles. A recall keeps `busy` high for DEPTH+EXTRA+1 cycles. `req_ready` is 0 while busy, so requests offered during that time are not taken.
- R4: A `sw_store` pulse while idle and `below_switch`=0 copies the whole RAM into the shadow, whether or not any write is unsaved. A `sw_store` pulse while `below_switch`=1 starts nothing.
- R5: A recall sets every RAM word to the matching shadow word and never changes the shadow. Repeated recalls give identical contents.
- R6: While idle with `below_switch`=1, an automatic store starts only if a write has been taken since the last completed store or recall.
- R7: The unsaved-write flag is set by each taken write with `below_switch`=0. It is cleared when a store or a recall completes.
- R8: Any cycle with `below_reset`=1 latches a recall request. That recall starts on the first idle cycle with `below_switch`=0 and `below_reset`=0.
- R9: If `sw_store` and `sw_recall` are both high in the same idle cycle, a store runs.
- R10: If a write request is pending in the final cycle of an automatic recall, `wr_err` rises on the next cycle. While `wr_err`=1, `req_ready` stays 0 and the write is never applied. `wr_err` clears once `req_valid` drops.
- R11: After reset, `busy`=0, `req_ready`=1, `rsp_valid`=0, `wr_err`=0, and every RAM word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | WIDTH | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | WIDTH | Read data |
| sw_store | input | 1 | Software store request (sampled while idle) |
| sw_recall | input | 1 | Software recall request (sampled while idle) |
| below_switch | input | 1 | Supply below the switch level |
| below_reset | input | 1 | Supply below the reset level |
| busy | output | 1 | Store or recall in progress |
| wr_err | output | 1 | A write was pending when an automatic recall ended |

## Verification
The hardest case to reach from the ports is a write request that is still pending in the last cycle of a power-up recall. Reaching it needs a reset-level dip, then a recovery, then a write raised only after the recall has begun.

The bench builds this case directly:
1. It raises both power-status inputs and then drops them.
2. It offers the write one cycle after `busy` rises, so the write cannot be taken before the recall starts.
3. It holds the write through the end of the recall and checks that the written value never reaches the RAM.

Around these directed cases, a seeded random mix of reads, writes and software operations is checked against a bench model of both arrays.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_CLEAR,
    ST_COPY,
    ST_SETTLE
  } seq_state_t;

  typedef enum logic {
    OP_STORE,
    OP_RECALL
  } op_kind_t;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             clr_all,
  input  logic             save_en,
  input  logic             load_en,
  input  logic [AW-1:0]    xfer_idx
);
  logic [WIDTH-1:0] ram_v [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [AW-1:0] IDX = AW'(g);
    logic [WIDTH-1:0] ram_q;
    logic [WIDTH-1:0] shd_q;

    // working word: clear beats load beats write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ram_q <= '0;
      end else if (clr_all) begin
        ram_q <= '0;
      end else if (load_en && xfer_idx == IDX) begin
        ram_q <= shd_q;
      end else if (wr_en && wr_addr == IDX) begin
        ram_q <= wr_data;
      end
    end

    // shadow word changes only during a store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
      end else if (save_en && xfer_idx == IDX) begin
        shd_q <= ram_q;
      end
    end

    assign ram_v[g] = ram_q;
  end

  assign rd_data = ram_v[rd_addr];
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EXTRA = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(EXTRA + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_store,
  input  logic          start_recall,
  output logic          busy,
  output logic          save_en,
  output logic          clr_all,
  output logic          load_en,
  output logic [AW-1:0] idx,
  output logic          op_done,
  output logic          done_recall
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(EXTRA - 1);

  seq_state_t state_q;
  op_kind_t   kind_q;
  logic [AW-1:0] idx_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= OP_STORE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          cnt_q <= '0;
          if (start_store) begin
            state_q <= ST_STORE;
            kind_q  <= OP_STORE;
          end else if (start_recall) begin
            state_q <= ST_CLEAR;
            kind_q  <= OP_RECALL;
          end
        end
        ST_CLEAR: begin
          state_q <= ST_COPY;
          idx_q   <= '0;
        end
        ST_STORE, ST_COPY: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == LAST_CNT) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign save_en     = (state_q == ST_STORE);
  assign load_en     = (state_q == ST_COPY);
  assign clr_all     = (state_q == ST_CLEAR);
  assign idx         = idx_q;
  assign op_done     = (state_q == ST_SETTLE) && (cnt_q == LAST_CNT);
  assign done_recall = op_done && (kind_q == OP_RECALL);
endmodule

// File: rtl/nvs_policy.sv
module nvs_policy (
  input  logic clk,
  input  logic rst_n,
  input  logic below_switch,
  input  logic below_reset,
  input  logic busy,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic wr_accept,
  input  logic op_done,
  input  logic done_recall,
  output logic start_store,
  output logic start_recall,
  output logic dirty_q,
  output logic rcl_auto_q
);
  logic pend_q;
  logic go_auto_rcl;
  logic go_auto_st;
  logic go_sw_st;
  logic go_sw_rcl;

  // priority: latched power-up recall, auto store, software store, software recall
  assign go_auto_rcl = !busy && pend_q && !below_switch && !below_reset;
  assign go_auto_st  = !busy && !go_auto_rcl && below_switch && dirty_q;
  assign go_sw_st    = !busy && !go_auto_rcl && !below_switch && sw_store;
  assign go_sw_rcl   = !busy && !go_auto_rcl && !below_switch && !sw_store && sw_recall;

  assign start_store  = go_auto_st || go_sw_st;
  assign start_recall = go_auto_rcl || go_sw_rcl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (below_reset) begin
      pend_q <= 1'b1;
    end else if (go_auto_rcl) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
    end else if (op_done) begin
      dirty_q <= 1'b0;
    end else if (wr_accept) begin
      dirty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcl_auto_q <= 1'b0;
    end else if (go_auto_rcl) begin
      rcl_auto_q <= 1'b1;
    end else if (done_recall) begin
      rcl_auto_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int EXTRA = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [WIDTH-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_rdata,
  input  logic             sw_store,
  input  logic             sw_recall,
  input  logic             below_switch,
  input  logic             below_reset,
  output logic             busy,
  output logic             wr_err
);
  logic          start_store, start_recall;
  logic          save_en, clr_all, load_en;
  logic [AW-1:0] idx;
  logic          op_done, done_recall;
  logic          dirty_q, rcl_auto_q;
  logic          corrupt_q;
  logic          wr_accept, rd_accept;
  logic [WIDTH-1:0] rd_word;

  assign req_ready = !busy && !corrupt_q;
  assign wr_accept = req_valid && req_ready && req_write && !below_switch;
  assign rd_accept = req_valid && req_ready && !req_write;

  nvs_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_accept),
    .wr_addr  (req_addr),
    .wr_data  (req_wdata),
    .rd_addr  (req_addr),
    .rd_data  (rd_word),
    .clr_all  (clr_all),
    .save_en  (save_en),
    .load_en  (load_en),
    .xfer_idx (idx)
  );

  nvs_seq #(.DEPTH(DEPTH), .EXTRA(EXTRA)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_store  (start_store),
    .start_recall (start_recall),
    .busy         (busy),
    .save_en      (save_en),
    .clr_all      (clr_all),
    .load_en      (load_en),
    .idx          (idx),
    .op_done      (op_done),
    .done_recall  (done_recall)
  );

  nvs_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .below_switch (below_switch),
    .below_reset  (below_reset),
    .busy         (busy),
    .sw_store     (sw_store),
    .sw_recall    (sw_recall),
    .wr_accept    (wr_accept),
    .op_done      (op_done),
    .done_recall  (done_recall),
    .start_store  (start_store),
    .start_recall (start_recall),
    .dirty_q      (dirty_q),
    .rcl_auto_q   (rcl_auto_q)
  );

  // refuse a write that was pending as the power-up recall finished
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrupt_q <= 1'b0;
    end else if (done_recall && rcl_auto_q && req_valid && req_write) begin
      corrupt_q <= 1'b1;
    end else if (!req_valid) begin
      corrupt_q <= 1'b0;
    end
  end
  assign wr_err = corrupt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_accept;
      if (rd_accept) begin
        rsp_rdata <= rd_word;
      end
    end
  end
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic rsp_valid,
  input logic busy,
  input logic wr_err,
  input logic below_switch,
  input logic dirty,
  input logic op_done,
  input logic rcl_auto,
  input logic start_store,
  input logic start_recall
);
  a_r3_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_store || start_recall) |=> busy);

  a_r1_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  a_r1_rsp_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  a_r7_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !below_switch) |=> dirty);

  a_r7_clean_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !dirty);

  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> $past(op_done && rcl_auto && req_valid && req_write));

  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !req_ready);
endmodule

bind nvsram_ctrl nvsram_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .rsp_valid    (rsp_valid),
  .busy         (busy),
  .wr_err       (wr_err),
  .below_switch (below_switch),
  .dirty        (dirty_q),
  .op_done      (op_done),
  .rcl_auto     (rcl_auto_q),
  .start_store  (start_store),
  .start_recall (start_recall)
);

// File: tb/nvsram_ctrl_tb.sv
module nvsram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int EXTRA = 2;
  localparam int AW = $clog2(DEPTH);
  localparam int ST_LEN = DEPTH + EXTRA;
  localparam int RC_LEN = DEPTH + EXTRA + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [WIDTH-1:0] req_wdata = '0;
  logic sw_store = 1'b0, sw_recall = 1'b0;
  logic below_switch = 1'b0, below_reset = 1'b0;
  logic req_ready, rsp_valid, busy, wr_err;
  logic [WIDTH-1:0] rsp_rdata;

  int nvec = 0;
  int nfail = 0;
  bit done_flag = 0;
  logic [WIDTH-1:0] m_ram [DEPTH];
  logic [WIDTH-1:0] m_shd [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nvsram_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .EXTRA(EXTRA)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sw_store(sw_store),
    .sw_recall(sw_recall), .below_switch(below_switch), .below_reset(below_reset),
    .busy(busy), .wr_err(wr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void m_store();
    for (int i = 0; i < DEPTH; i++) m_shd[i] = m_ram[i];
  endfunction

  function automatic void m_recall();
    for (int i = 0; i < DEPTH; i++) m_ram[i] = m_shd[i];
  endfunction

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = WIDTH'(d);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(input int a, input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 0;
    chk(req, int'(rsp_valid), 1);
    chk(req, int'(rsp_rdata), int'(m_ram[a]));
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_op(input bit st, input bit rc, output int n);
    @(negedge clk);
    sw_store = st; sw_recall = rc;
    @(negedge clk);
    sw_store = 0; sw_recall = 0;
    busy_len(n);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h1d5e_a7c3));
    for (int i = 0; i < DEPTH; i++) begin m_ram[i] = '0; m_shd[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 rsp_valid", int'(rsp_valid), 0);
    chk("R11 wr_err", int'(wr_err), 0);
    do_read(5, "R11 zero word");

    // R1 R2 basic writes
    for (int i = 0; i < DEPTH; i++) begin
      do_write(i, i * 17 + 3); m_ram[i] = WIDTH'(i * 17 + 3);
    end
    do_read(0, "R1 read a0");
    do_read(DEPTH - 1, "R1 read last");

    // R4 R3 store duration
    pulse_op(1, 0, n); m_store();
    chk("R3 store length", n, ST_LEN);
    // R4 store without unsaved writes still runs
    pulse_op(1, 0, n);
    chk("R4 clean store runs", n, ST_LEN);

    // R5 recall restores and is repeatable
    do_write(4, 8'hA5); m_ram[4] = 8'hA5;
    pulse_op(0, 1, n); m_recall();
    chk("R3 recall length", n, RC_LEN);
    do_read(4, "R5 recall restores");
    pulse_op(0, 1, n); m_recall();
    do_read(4, "R5 second recall same");
    do_read(9, "R5 second recall other");

    // R9 simultaneous: store wins
    do_write(2, 8'h3C); m_ram[2] = 8'h3C;
    pulse_op(1, 1, n); m_store();
    chk("R9 store wins length", n, ST_LEN);
    do_write(2, 8'h00); m_ram[2] = 8'h00;
    pulse_op(0, 1, n); m_recall();
    do_read(2, "R9 shadow took store");

    // R3 request during busy is not taken
    @(negedge clk); sw_store = 1;
    @(negedge clk); sw_store = 0;
    req_valid = 1; req_write = 1; req_addr = 3; req_wdata = 8'hEE;
    @(negedge clk);
    chk("R3 ready low while busy", int'(req_ready), 0);
    req_valid = 0; req_write = 0;
    busy_len(n); m_store();
    do_read(3, "R3 write dropped while busy");

    // R6 no auto store when clean (last op completed, no write since)
    @(negedge clk); below_switch = 1;
    n = 0;
    repeat (30) begin @(negedge clk); if (busy) n++; end
    chk("R6 clean no auto store", n, 0);
    // R2 write under low supply ignored; R4 sw store blocked
    do_write(6, 8'h77);
    do_read(6, "R2 low-supply write ignored");
    pulse_op(1, 0, n);
    chk("R4 sw store blocked low", n, 0);
    repeat (5) @(negedge clk);
    chk("R7 no auto store after ignored write", int'(busy), 0);
    below_switch = 0;

    // R6 R7 dirty triggers auto store
    do_write(7, 8'h5A); m_ram[7] = 8'h5A;
    @(negedge clk); below_switch = 1;
    @(negedge clk);
    busy_len(n); m_store();
    chk("R6 auto store length", n, ST_LEN);
    repeat (10) @(negedge clk);
    chk("R7 one auto store only", int'(busy), 0);
    below_switch = 0;
    do_write(7, 8'h11); m_ram[7] = 8'h11;
    pulse_op(0, 1, n); m_recall();
    do_read(7, "R6 auto store saved word");

    // R8 power-up recall
    do_write(8, 8'hC3); m_ram[8] = 8'hC3;
    pulse_op(1, 0, n); m_store();
    do_write(8, 8'h01); m_ram[8] = 8'h01;
    pulse_op(1, 0, n); m_store();
    do_write(8, 8'h99); m_ram[8] = 8'h99;
    @(negedge clk); below_switch = 1; below_reset = 1;
    @(negedge clk);
    busy_len(n); m_store();
    repeat (4) @(negedge clk);
    below_reset = 0;
    repeat (3) @(negedge clk);
    chk("R8 waits for switch level", int'(busy), 0);
    below_switch = 0;
    @(negedge clk);
    busy_len(n); m_recall();
    chk("R8 power-up recall length", n, RC_LEN);
    do_read(8, "R8 recall data");

    // R10 write pending at end of power-up recall
    @(negedge clk); below_switch = 1; below_reset = 1;
    repeat (3) @(negedge clk);
    below_switch = 0; below_reset = 0;
    @(negedge clk);
    chk("R8 recall started", int'(busy), 1);
    req_valid = 1; req_write = 1; req_addr = 1; req_wdata = 8'hF0;
    busy_len(n); m_recall();
    chk("R10 wr_err set", int'(wr_err), 1);
    chk("R10 ready held low", int'(req_ready), 0);
    @(negedge clk);
    chk("R10 wr_err held", int'(wr_err), 1);
    req_valid = 0; req_write = 0;
    @(negedge clk);
    chk("R10 wr_err cleared", int'(wr_err), 0);
    do_read(1, "R10 write never applied");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int sel = int'($urandom_range(0, 9));
      int a = int'($urandom_range(0, DEPTH - 1));
      int d = int'($urandom_range(0, 255));
      if (sel < 4) begin
        do_write(a, d); m_ram[a] = WIDTH'(d);
      end else if (sel < 8) begin
        do_read(a, "R1 random read");
      end else if (sel == 8) begin
        pulse_op(1, 0, n); m_store();
        chk("R3 random store length", n, ST_LEN);
      end else begin
        pulse_op(0, 1, n); m_recall();
        chk("R5 random recall length", n, RC_LEN);
      end
    end
    for (int i = 0; i < DEPTH; i++) do_read(i, "R5 final sweep");
    finish_run();
  end
endmodule